// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard control for a five-stage in-order pipeline. The stages are fetch, decode with register read, execute, memory and writeback. It looks at the source registers of the instruction in decode and at the destinations of the three older instructions in flight. From these it decides one of three things each cycle: the decode-stage operands take bypassed data, the front of the pipeline freezes, or the two youngest instructions are thrown away because a branch was taken.

Branches resolve in execute. There are no delay slots, so a taken branch kills the instruction in decode and the instruction arriving from fetch. When bypassing is built in, forwarded values are steered into the operand latches at the end of the register-read stage. Only a load immediately followed by a consumer of its result costs a cycle. When bypassing is left out, a consumer waits in decode until its producer has written the register file.

The block is purely combinational. The datapath registers take its hold, bubble and squash outputs at their next clock edge.

Top module: `hazard_ctl`

## Requirements
- R1: When `br_taken` is 1, the block drives `ifid_squash`=1, `fetch_squash`=1, `idex_bubble`=1, `pc_hold`=0 and `ifid_hold`=0, and every bypass select is 0. This holds whatever hazard is present in the same cycle.
- R2: With bypassing built in, a used source that matches a non-load writer in execute selects code 3 (execute result) and causes no stall.
- R3: With bypassing built in, a used source that matches a load in execute raises `pc_hold`, `ifid_hold` and `idex_bubble` for that cycle, and all selects are 0. Once the load has moved on to memory, the same source selects code 2 without a stall.
- R4: When several writers match one source, the youngest one wins. Execute beats memory, and memory beats writeback.
- R5: With bypassing built in, a match only in memory selects code 2, and a match only in writeback selects code 1. No match selects code 0 (register file).
- R6: Source index 0 never causes a stall or a non-zero select.
- R7: A source whose `id_src_used` bit is 0 never causes a stall or a non-zero select.
- R8: A writer whose write enable is 0 never matches.
- R9: With bypassing left out, any used non-zero source that matches a writer in execute, memory or writeback causes a stall, and all selects stay 0. A consumer directly behind its producer therefore stalls for three cycles.
- R10: Each source resolves on its own. Source k's select sits in `byp_sel[2k+1:2k]`. A stall from either source stalls the instruction and forces both selects to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_idx | input | NUM_SRC*IDX_W | Source register indices of the decode-stage instruction; source k in bits [k*IDX_W +: IDX_W] |
| id_src_used | input | NUM_SRC | Bit k is 1 when source k is read |
| ex_dst | input | IDX_W | Destination of the instruction in execute |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | IDX_W | Destination of the instruction in memory |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | IDX_W | Destination of the instruction in writeback |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| br_taken | input | 1 | Branch in execute is taken |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ifid_squash | output | 1 | Kill the instruction now in decode |
| fetch_squash | output | 1 | Kill the instruction now being fetched |
| byp_sel | output | NUM_SRC*2 | Per-source select: 0 register file, 1 writeback, 2 memory, 3 execute |

## Verification
The bench builds two copies with 5-bit indices and two sources side by side. One copy has bypassing built in and the other has it left out. Every stimulus is checked against both copies at once. This shows, for the same hazard, the split between forwarding with a single load stall and plain waiting until writeback. It also shows that branch squash and the index-0 and unused-operand exclusions behave the same in both variants. Short directed sequences step a producer through execute, memory and writeback. They show the one-cycle load penalty and the three-cycle wait without bypass.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // operand source, numeric codes are part of the datapath mux contract
   typedef enum logic [1:0] {
      BYP_RF  = 2'd0,
      BYP_WB  = 2'd1,
      BYP_MEM = 2'd2,
      BYP_EX  = 2'd3
   } byp_sel_e;

   localparam int SEL_W = $bits(byp_sel_e);

   // which older stage holds a pending write of one source register
   typedef struct packed {
      logic ex_alu;
      logic ex_ld;
      logic mem;
      logic wb;
   } stage_hit_t;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
   import hzd_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic             src_used,
   input  logic [IDX_W-1:0] ex_dst,
   input  logic             ex_we,
   input  logic             ex_is_load,
   input  logic [IDX_W-1:0] mem_dst,
   input  logic             mem_we,
   input  logic [IDX_W-1:0] wb_dst,
   input  logic             wb_we,
   output stage_hit_t       hit
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [IDX_W-1:0] ZERO_IDX = '0;

   logic live;
   logic ex_match;

   // register zero reads as zero, an unread operand cares about nothing
   assign live     = src_used && (src_idx != ZERO_IDX);
   assign ex_match = live && ex_we && (ex_dst == src_idx);

   assign hit.ex_alu = ex_match && !ex_is_load;
   assign hit.ex_ld  = ex_match &&  ex_is_load;
   assign hit.mem    = live && mem_we && (mem_dst == src_idx);
   assign hit.wb     = live && wb_we  && (wb_dst  == src_idx);
endmodule

// File: rtl/hzd_src_resolve.sv
module hzd_src_resolve
   import hzd_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
) (
   input  stage_hit_t hit,
   output logic       need_stall,
   output byp_sel_e   sel
);
   timeunit 1ns;
   timeprecision 1ps;

   if (BYPASS_EN) begin : g_fwd
      // youngest writer first; a load in execute has no data yet
      always_comb begin
         need_stall = 1'b0;
         sel        = BYP_RF;
         if (hit.ex_ld)       need_stall = 1'b1;
         else if (hit.ex_alu) sel = BYP_EX;
         else if (hit.mem)    sel = BYP_MEM;
         else if (hit.wb)     sel = BYP_WB;
      end
   end else begin : g_wait
      // no bypass network: wait until the register file holds the value
      assign need_stall = |hit;
      assign sel        = BYP_RF;
   end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
   import hzd_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter int NUM_SRC   = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [NUM_SRC*IDX_W-1:0] id_src_idx,
   input  logic [NUM_SRC-1:0]       id_src_used,
   input  logic [IDX_W-1:0]         ex_dst,
   input  logic                     ex_we,
   input  logic                     ex_is_load,
   input  logic [IDX_W-1:0]         mem_dst,
   input  logic                     mem_we,
   input  logic [IDX_W-1:0]         wb_dst,
   input  logic                     wb_we,
   input  logic                     br_taken,
   output logic                     pc_hold,
   output logic                     ifid_hold,
   output logic                     idex_bubble,
   output logic                     ifid_squash,
   output logic                     fetch_squash,
   output logic [NUM_SRC*2-1:0]     byp_sel
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int SELS_W = NUM_SRC * SEL_W;

   if (IDX_W < 1) begin : g_bad_idx
      $error("hazard_ctl: IDX_W must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("hazard_ctl: NUM_SRC must be at least 1");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("hazard_ctl: select encoding must be 2 bits");
   end

   logic [NUM_SRC-1:0] op_stall;
   logic [SELS_W-1:0]  sel_flat;
   logic               raw_stall;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      stage_hit_t hit;
      byp_sel_e   sel;

      hzd_src_match #(.IDX_W(IDX_W)) i_match (
         .src_idx    (id_src_idx[k*IDX_W +: IDX_W]),
         .src_used   (id_src_used[k]),
         .ex_dst     (ex_dst),
         .ex_we      (ex_we),
         .ex_is_load (ex_is_load),
         .mem_dst    (mem_dst),
         .mem_we     (mem_we),
         .wb_dst     (wb_dst),
         .wb_we      (wb_we),
         .hit        (hit)
      );

      hzd_src_resolve #(.BYPASS_EN(BYPASS_EN)) i_resolve (
         .hit        (hit),
         .need_stall (op_stall[k]),
         .sel        (sel)
      );

      assign sel_flat[k*SEL_W +: SEL_W] = sel;
   end

   assign raw_stall = |op_stall;

   // a taken branch kills the decode instruction anyway, so it wins over a stall
   always_comb begin
      if (br_taken) begin
         pc_hold      = 1'b0;
         ifid_hold    = 1'b0;
         idex_bubble  = 1'b1;
         ifid_squash  = 1'b1;
         fetch_squash = 1'b1;
         byp_sel      = '0;
      end else begin
         pc_hold      = raw_stall;
         ifid_hold    = raw_stall;
         idex_bubble  = raw_stall;
         ifid_squash  = 1'b0;
         fetch_squash = 1'b0;
         byp_sel      = raw_stall ? '0 : sel_flat;
      end
   end
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
   parameter int IDX_W     = 5,
   parameter int NUM_SRC   = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input logic [NUM_SRC*IDX_W-1:0] id_src_idx,
   input logic [NUM_SRC-1:0]       id_src_used,
   input logic                     ex_is_load,
   input logic                     br_taken,
   input logic                     pc_hold,
   input logic                     ifid_hold,
   input logic                     idex_bubble,
   input logic                     ifid_squash,
   input logic                     fetch_squash,
   input logic [NUM_SRC*2-1:0]     byp_sel
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      if (br_taken) begin
         a_r1_squash_wins: assert (!pc_hold && !ifid_hold && idex_bubble
                                   && ifid_squash && fetch_squash && byp_sel == '0)
            else $error("squash did not override");
      end
      if (pc_hold) begin
         a_r3_hold_bubbles: assert (ifid_hold && idex_bubble && !ifid_squash)
            else $error("stall without full freeze");
      end
      if (BYPASS_EN && !ex_is_load && !br_taken) begin
         a_r2_fwd_no_stall: assert (!pc_hold)
            else $error("stall with no load in execute");
      end
      if (!BYPASS_EN) begin
         a_r9_wait_no_sel: assert (byp_sel == '0)
            else $error("select raised without bypass");
      end
      for (int k = 0; k < NUM_SRC; k++) begin
         if (id_src_idx[k*IDX_W +: IDX_W] == '0) begin
            a_r6_zero_quiet: assert (byp_sel[k*2 +: 2] == 2'd0)
               else $error("index zero forwarded");
         end
         if (!id_src_used[k]) begin
            a_r7_unused_quiet: assert (byp_sel[k*2 +: 2] == 2'd0)
               else $error("unused operand forwarded");
         end
      end
   end
endmodule

bind hazard_ctl hazard_ctl_chk #(
   .IDX_W     (IDX_W),
   .NUM_SRC   (NUM_SRC),
   .BYPASS_EN (BYPASS_EN)
) i_chk (
   .id_src_idx   (id_src_idx),
   .id_src_used  (id_src_used),
   .ex_is_load   (ex_is_load),
   .br_taken     (br_taken),
   .pc_hold      (pc_hold),
   .ifid_hold    (ifid_hold),
   .idex_bubble  (idex_bubble),
   .ifid_squash  (ifid_squash),
   .fetch_squash (fetch_squash),
   .byp_sel      (byp_sel)
);

// File: tb/test_hazard_ctl.sv
module test_hazard_ctl;
   timeunit 1ns;
   timeprecision 1ps;

   typedef struct packed {
      logic [23:0] tag;
      logic [4:0]  s0;
      logic [4:0]  s1;
      logic [1:0]  used;
      logic [4:0]  exd;
      logic        exw;
      logic        exl;
      logic [4:0]  memd;
      logic        memw;
      logic [4:0]  wbd;
      logic        wbw;
      logic        br;
      logic        e_stall;
      logic        e_kill;
      logic [3:0]  e_sel;   // {src1, src0}
      logic        e_nb;    // stall expected with bypass left out
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{"R2 ", 5'd1,  5'd2,  2'b11, 5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 4'b0011, 1'b1},
      '{"R5 ", 5'd3,  5'd4,  2'b11, 5'd0,  1'b0, 1'b0, 5'd4,  1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b1},
      '{"R5 ", 5'd7,  5'd8,  2'b11, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd7,  1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b1},
      '{"R4 ", 5'd5,  5'd5,  2'b11, 5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 5'd5,  1'b1, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b1},
      '{"R4 ", 5'd6,  5'd9,  2'b11, 5'd0,  1'b0, 1'b0, 5'd6,  1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b1},
      '{"R3 ", 5'd10, 5'd11, 2'b11, 5'd10, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1},
      '{"R7 ", 5'd10, 5'd11, 2'b10, 5'd10, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0},
      '{"R6 ", 5'd0,  5'd0,  2'b11, 5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0},
      '{"R8 ", 5'd12, 5'd12, 2'b11, 5'd12, 1'b0, 1'b1, 5'd12, 1'b0, 5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0},
      '{"R1 ", 5'd10, 5'd11, 2'b11, 5'd10, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0},
      '{"R10", 5'd13, 5'd14, 2'b11, 5'd14, 1'b1, 1'b1, 5'd13, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1},
      '{"R10", 5'd15, 5'd16, 2'b11, 5'd15, 1'b1, 1'b0, 5'd0,  1'b0, 5'd16, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0111, 1'b1},
      '{"R1 ", 5'd1,  5'd2,  2'b11, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0},
      '{"R7 ", 5'd20, 5'd21, 2'b01, 5'd21, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [9:0] id_src_idx;
   logic [1:0] id_src_used;
   logic [4:0] ex_dst, mem_dst, wb_dst;
   logic       ex_we, ex_is_load, mem_we, wb_we, br_taken;

   logic       f_pc, f_ifid, f_bub, f_sq, f_fsq;
   logic [3:0] f_sel;
   logic       w_pc, w_ifid, w_bub, w_sq, w_fsq;
   logic [3:0] w_sel;

   hazard_ctl #(.IDX_W(5), .NUM_SRC(2), .BYPASS_EN(1'b1)) i_hazard_ctl (
      .id_src_idx (id_src_idx), .id_src_used (id_src_used),
      .ex_dst (ex_dst), .ex_we (ex_we), .ex_is_load (ex_is_load),
      .mem_dst (mem_dst), .mem_we (mem_we), .wb_dst (wb_dst), .wb_we (wb_we),
      .br_taken (br_taken),
      .pc_hold (f_pc), .ifid_hold (f_ifid), .idex_bubble (f_bub),
      .ifid_squash (f_sq), .fetch_squash (f_fsq), .byp_sel (f_sel)
   );

   hazard_ctl #(.IDX_W(5), .NUM_SRC(2), .BYPASS_EN(1'b0)) i_hazard_ctl_nobyp (
      .id_src_idx (id_src_idx), .id_src_used (id_src_used),
      .ex_dst (ex_dst), .ex_we (ex_we), .ex_is_load (ex_is_load),
      .mem_dst (mem_dst), .mem_we (mem_we), .wb_dst (wb_dst), .wb_we (wb_we),
      .br_taken (br_taken),
      .pc_hold (w_pc), .ifid_hold (w_ifid), .idex_bubble (w_bub),
      .ifid_squash (w_sq), .fetch_squash (w_fsq), .byp_sel (w_sel)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   task automatic check_fwd(input string tag, input logic stall, input logic kill,
                            input logic [3:0] sel);
      logic [8:0] act, exp;
      act = {f_pc, f_ifid, f_bub, f_sq, f_fsq, f_sel};
      exp = {stall, stall, stall | kill, kill, kill, sel};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s bypass copy: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic check_wait(input string tag, input logic stall, input logic kill);
      logic [8:0] act, exp;
      act = {w_pc, w_ifid, w_bub, w_sq, w_fsq, w_sel};
      exp = {stall, stall, stall | kill, kill, kill, 4'b0000};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s no-bypass copy: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] s0, input logic [4:0] s1, input logic [1:0] used,
                        input logic [4:0] exd, input logic exw, input logic exl,
                        input logic [4:0] memd, input logic memw,
                        input logic [4:0] wbd, input logic wbw, input logic br);
      @(negedge clk);
      id_src_idx  = {s1, s0};
      id_src_used = used;
      ex_dst = exd;  ex_we = exw;  ex_is_load = exl;
      mem_dst = memd; mem_we = memw;
      wb_dst = wbd;  wb_we = wbw;
      br_taken = br;
      #1;
   endtask

   initial begin
      id_src_idx = '0; id_src_used = '0;
      ex_dst = '0; ex_we = 1'b0; ex_is_load = 1'b0;
      mem_dst = '0; mem_we = 1'b0; wb_dst = '0; wb_we = 1'b0;
      br_taken = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset state: all-zero inputs, only index 0 in view (R6)
      @(negedge clk); #1;
      check_fwd("R6", 1'b0, 1'b0, 4'b0000);
      check_wait("R6", 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].s0, VEC[i].s1, VEC[i].used, VEC[i].exd, VEC[i].exw, VEC[i].exl,
               VEC[i].memd, VEC[i].memw, VEC[i].wbd, VEC[i].wbw, VEC[i].br);
         check_fwd(string'(VEC[i].tag), VEC[i].e_stall, VEC[i].e_kill, VEC[i].e_sel);
         check_wait(string'(VEC[i].tag), VEC[i].e_nb, VEC[i].e_kill);
      end

      // R3: load-use, one stall then memory-stage forward
      drive(5'd4, 5'd0, 2'b01, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
      check_fwd("R3", 1'b1, 1'b0, 4'b0000);
      drive(5'd4, 5'd0, 2'b01, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 1'b0);
      check_fwd("R3", 1'b0, 1'b0, 4'b0010);

      // R9: producer walks EX, MEM, WB, then gone; count waiting cycles
      begin
         int stalls;
         stalls = 0;
         drive(5'd9, 5'd0, 2'b01, 5'd9, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
         stalls += int'(w_pc);
         check_fwd("R2", 1'b0, 1'b0, 4'b0011);
         drive(5'd9, 5'd0, 2'b01, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd0, 1'b0, 1'b0);
         stalls += int'(w_pc);
         check_fwd("R5", 1'b0, 1'b0, 4'b0010);
         drive(5'd9, 5'd0, 2'b01, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd9, 1'b1, 1'b0);
         stalls += int'(w_pc);
         check_fwd("R5", 1'b0, 1'b0, 4'b0001);
         drive(5'd9, 5'd0, 2'b01, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
         check_wait("R9", 1'b0, 1'b0);
         n_chk++;
         if (stalls != 3) begin
            n_fail++;
            $display("FAIL R9 stall cycles: actual %0d expected 3", stalls);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule